// File: doc/BRIEF.md
# Serial Controller Interrupt Identification Unit

This block combines the four interrupt causes of a byte-oriented serial controller into a single interrupt request. It also produces the identification byte that the CPU reads to find out which cause to service first. Each cause has its own latched pending flag, and each flag has its own rule for how it is set and cleared. The interrupt enable bits decide which pending flags may reach the request output and the identification code. A pending flag whose enable bit is 0 keeps its latched state but drives neither the request nor the code.

The receiver, the transmitter and the modem-line logic deliver one-cycle event strobes to the block. The bus decoder delivers one-cycle read strobes for the line status, receive buffer, identification and modem status registers, plus a write strobe for the transmit holding register. The request and the identification byte are combinational functions of the registered pending flags and the enable bits. A strobe therefore becomes visible one clock edge after it is presented.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset every pending flag is clear, so `irq` is 0 and `id_byte` is 0x01. Also after reset the transmit holding register counts as empty and the previous transmit-empty enable counts as 0.
- R2: Any bit of `line_err` (overrun, parity, framing, break) sets the line-status flag. `lsr_rd` clears it. Its code in `id_byte[2:1]` is 2'b11.
- R3: `rx_ready` sets the receive-data flag and `rbr_rd` clears it. Its code is 2'b10.
- R4: `thr_empty_evt` sets the transmit-empty flag and `thr_wr` clears it. Its code is 2'b01.
- R5: `id_rd` clears the transmit-empty flag only while code 2'b01 is the cause being reported. If a higher-priority cause is being reported, `id_rd` leaves the transmit-empty flag pending.
- R6: Any bit of `modem_evt` (clear-to-send change, data-set-ready change, carrier-detect change, ring trailing edge) sets the modem flag. `msr_rd` clears it. Its code is 2'b00.
- R7: When several enabled causes are pending, the code reports the highest one. The order from highest to lowest is line status, receive data, transmit empty, modem.
- R8: `int_en` bit 0 enables receive data, bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem. A pending cause whose enable bit is 0 stays latched but does not affect `irq` or the code. Setting that enable bit later reports the cause immediately.
- R9: `irq` is the OR of the causes that are both enabled and pending. `id_byte[0]` equals the inverse of `irq`, and `id_byte[7:3]` is always 0.
- R10: When `int_en[1]` goes from 0 to 1 while the holding register is empty, the transmit-empty flag becomes pending. The holding register is empty after `thr_empty_evt` and until `thr_wr`.
- R11: When a set event and its clearing strobe arrive in the same cycle, the flag is pending afterwards.
- R12: A flag changes at the first clock edge after its strobe. `irq` and `id_byte` follow that flag in the same cycle, and they follow `int_en` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_en | input | 4 | Interrupt enable bits |
| line_err | input | 4 | Receiver error strobes: overrun, parity, framing, break |
| rx_ready | input | 1 | Received byte available strobe |
| thr_empty_evt | input | 1 | Transmit holding register became empty strobe |
| modem_evt | input | 4 | Modem line change strobes |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| id_rd | input | 1 | Identification register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| irq | output | 1 | Interrupt request |
| id_byte | output | 8 | Identification byte: bit 0 active-low pending, bits 2:1 code |

## Verification
Each strobe is driven at a falling edge and removed at the next falling edge. Its effect is due at the rising edge in between, so the directed checks sample at the following falling edge. One extra check samples just after driving a strobe and confirms that nothing has moved before the edge. The effect of `int_en` on `irq` and `id_byte` is combinational, so it is checked in the same half cycle in which the enable changes. The effect of a rising transmit-empty enable on the pending flag is checked one edge later. A behavioural reference model updates at every rising edge, and the outputs are compared against it 1 ns after that edge, once the registers have settled.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int unsigned NUM_SRC = 4;
   localparam int unsigned CODE_W  = $clog2(NUM_SRC);

   // Source index equals the code it reports; higher index means higher priority.
   localparam int unsigned SRC_MS = 0;
   localparam int unsigned SRC_TX = 1;
   localparam int unsigned SRC_RX = 2;
   localparam int unsigned SRC_LS = 3;

   typedef enum logic [CODE_W-1:0] {
      CODE_MODEM = 2'b00,
      CODE_TXEMP = 2'b01,
      CODE_RXDAT = 2'b10,
      CODE_LINE  = 2'b11
   } irq_code_e;

   // Position of each source's enable bit inside the enable input.
   localparam int unsigned EN_RX = 0;
   localparam int unsigned EN_TX = 1;
   localparam int unsigned EN_LS = 2;
   localparam int unsigned EN_MS = 3;

endpackage

// File: rtl/irq_pend_cell.sv
module irq_pend_cell #(
   parameter int unsigned SET_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] set_i,
   input  logic             clr_i,
   output logic             pend_o
);

   generate
      if (SET_W < 1) begin : g_bad_w
         $error("irq_pend_cell: SET_W must be at least 1");
      end
   endgenerate

   logic any_set;
   assign any_set = |set_i;

   // A new event outranks a clearing access in the same cycle.
   always_ff @(posedge clk) begin
      if (!rst_n)       pend_o <= 1'b0;
      else if (any_set) pend_o <= 1'b1;
      else if (clr_i)   pend_o <= 1'b0;
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      any_set |=> pend_o); // R11

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !any_set) |=> !pend_o); // R2

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int unsigned N = 4,
   parameter int unsigned W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] active_i,
   output logic         any_o,
   output logic [W-1:0] code_o
);

   generate
      if (N < 2) begin : g_bad_n
         $error("irq_prio_enc: N must be at least 2");
      end
      if ((1 << W) < N) begin : g_bad_w
         $error("irq_prio_enc: W too narrow for N");
      end
   endgenerate

   always_comb begin
      code_o = '0;
      for (int i = 0; i < N; i++) begin
         if (active_i[i]) code_o = W'(i);
      end
   end

   assign any_o = |active_i;

endmodule

// File: rtl/thr_empty_track.sv
module thr_empty_track (
   input  logic clk,
   input  logic rst_n,
   input  logic empty_evt_i,
   input  logic thr_wr_i,
   input  logic en_i,
   output logic arm_o
);

   logic empty_q;
   logic en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         empty_q <= 1'b1;
         en_q    <= 1'b0;
      end else begin
         en_q <= en_i;
         if (empty_evt_i)   empty_q <= 1'b1;
         else if (thr_wr_i) empty_q <= 1'b0;
      end
   end

   // Enable rising while the holding register is already empty.
   assign arm_o = en_i && !en_q && empty_q;

   AST_WR_EMPTIES_GONE: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr_i && !empty_evt_i) |=> !empty_q); // R10

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int unsigned LINE_ERR_W = 4,
   parameter int unsigned MODEM_W    = 4,
   parameter int unsigned EN_W       = 4,
   parameter int unsigned ID_W       = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [EN_W-1:0]       int_en,
   input  logic [LINE_ERR_W-1:0] line_err,
   input  logic                  rx_ready,
   input  logic                  thr_empty_evt,
   input  logic [MODEM_W-1:0]    modem_evt,
   input  logic                  lsr_rd,
   input  logic                  rbr_rd,
   input  logic                  id_rd,
   input  logic                  msr_rd,
   input  logic                  thr_wr,
   output logic                  irq,
   output logic [ID_W-1:0]       id_byte
);

   localparam int unsigned PAD_W = ID_W - CODE_W - 1;

   generate
      if (EN_W != NUM_SRC) begin : g_bad_en
         $error("uart_irq_ident: EN_W must equal the number of sources");
      end
      if (ID_W < CODE_W + 2) begin : g_bad_id
         $error("uart_irq_ident: ID_W too narrow");
      end
   endgenerate

   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] src_en;
   logic [NUM_SRC-1:0] active;
   logic [NUM_SRC-1:0] clr;
   logic [CODE_W-1:0]  code;
   logic               any_active;
   logic               tx_arm;

   // Reorder the enable bits into source-priority order.
   assign src_en[SRC_LS] = int_en[EN_LS];
   assign src_en[SRC_RX] = int_en[EN_RX];
   assign src_en[SRC_TX] = int_en[EN_TX];
   assign src_en[SRC_MS] = int_en[EN_MS];

   assign active = pend & src_en;

   thr_empty_track u_thr (
      .clk         (clk),
      .rst_n       (rst_n),
      .empty_evt_i (thr_empty_evt),
      .thr_wr_i    (thr_wr),
      .en_i        (int_en[EN_TX]),
      .arm_o       (tx_arm)
   );

   irq_prio_enc #(.N(NUM_SRC), .W(CODE_W)) u_enc (
      .active_i (active),
      .any_o    (any_active),
      .code_o   (code)
   );

   assign clr[SRC_LS] = lsr_rd;
   assign clr[SRC_RX] = rbr_rd;
   assign clr[SRC_MS] = msr_rd;
   assign clr[SRC_TX] = thr_wr || (id_rd && any_active && (code == CODE_TXEMP));

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         if (s == SRC_LS) begin : g_ls
            irq_pend_cell #(.SET_W(LINE_ERR_W)) u_cell (
               .clk(clk), .rst_n(rst_n), .set_i(line_err),
               .clr_i(clr[s]), .pend_o(pend[s]));
         end else if (s == SRC_MS) begin : g_ms
            irq_pend_cell #(.SET_W(MODEM_W)) u_cell (
               .clk(clk), .rst_n(rst_n), .set_i(modem_evt),
               .clr_i(clr[s]), .pend_o(pend[s]));
         end else if (s == SRC_TX) begin : g_tx
            irq_pend_cell #(.SET_W(2)) u_cell (
               .clk(clk), .rst_n(rst_n), .set_i({thr_empty_evt, tx_arm}),
               .clr_i(clr[s]), .pend_o(pend[s]));
         end else begin : g_rx
            irq_pend_cell #(.SET_W(1)) u_cell (
               .clk(clk), .rst_n(rst_n), .set_i(rx_ready),
               .clr_i(clr[s]), .pend_o(pend[s]));
         end
      end
   endgenerate

   assign irq     = any_active;
   assign id_byte = {{PAD_W{1'b0}}, code, ~any_active};

   AST_IDLE_ID: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> (id_byte == ID_W'(1))); // R9

   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (int_en == '0) |-> !irq); // R8

   AST_RX_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |=> pend[SRC_RX]); // R3

   AST_MS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_rd && (modem_evt == '0)) |=> !pend[SRC_MS]); // R6

   AST_TX_KEPT_UNDER_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
      (id_rd && pend[SRC_TX] && active[SRC_LS] && !thr_wr) |=> pend[SRC_TX]); // R5

   AST_TX_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr && !thr_empty_evt && !tx_arm) |=> !pend[SRC_TX]); // R4

endmodule

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] int_en = '0;
   logic [3:0] line_err = '0;
   logic       rx_ready = 1'b0;
   logic       thr_empty_evt = 1'b0;
   logic [3:0] modem_evt = '0;
   logic       lsr_rd = 1'b0, rbr_rd = 1'b0, id_rd = 1'b0, msr_rd = 1'b0, thr_wr = 1'b0;
   logic       irq;
   logic [7:0] id_byte;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   uart_irq_ident dut (
      .clk(clk), .rst_n(rst_n), .int_en(int_en), .line_err(line_err),
      .rx_ready(rx_ready), .thr_empty_evt(thr_empty_evt), .modem_evt(modem_evt),
      .lsr_rd(lsr_rd), .rbr_rd(rbr_rd), .id_rd(id_rd), .msr_rd(msr_rd),
      .thr_wr(thr_wr), .irq(irq), .id_byte(id_byte)
   );

   // Behavioural reference model.
   bit m_ls, m_rx, m_tx, m_ms, m_empty, m_enq;

   function automatic bit [7:0] model_id();
      if (m_ls && int_en[2]) return 8'h06;
      if (m_rx && int_en[0]) return 8'h04;
      if (m_tx && int_en[1]) return 8'h02;
      if (m_ms && int_en[3]) return 8'h00;
      return 8'h01;
   endfunction

   always @(posedge clk) begin
      bit [7:0] cur;
      if (!rst_n) begin
         m_ls = 0; m_rx = 0; m_tx = 0; m_ms = 0; m_empty = 1; m_enq = 0;
      end else begin
         cur = model_id();
         if (line_err != 0) m_ls = 1; else if (lsr_rd) m_ls = 0;
         if (rx_ready) m_rx = 1; else if (rbr_rd) m_rx = 0;
         if (modem_evt != 0) m_ms = 1; else if (msr_rd) m_ms = 0;
         if (thr_empty_evt || (int_en[1] && !m_enq && m_empty)) m_tx = 1;
         else if (thr_wr || (id_rd && cur == 8'h02)) m_tx = 0;
         if (thr_empty_evt) m_empty = 1; else if (thr_wr) m_empty = 0;
         m_enq = int_en[1];
      end
      #1;
      if (!done) begin
         vectors++;
         if (id_byte !== model_id() || irq !== (model_id() != 8'h01)) begin
            miscompares++;
            $display("FAIL R12/R9 model: id=%02h irq=%0b expected id=%02h irq=%0b",
                     id_byte, irq, model_id(), model_id() != 8'h01);
         end
      end
   end

   task automatic check(string rtag, bit [7:0] exp_id);
      bit exp_irq;
      exp_irq = (exp_id != 8'h01);
      vectors++;
      if (id_byte !== exp_id || irq !== exp_irq || id_byte[0] !== ~irq) begin
         miscompares++;
         $display("FAIL %s: id=%02h irq=%0b expected id=%02h irq=%0b",
                  rtag, id_byte, irq, exp_id, exp_irq);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      line_err = '0; rx_ready = 0; thr_empty_evt = 0; modem_evt = '0;
      lsr_rd = 0; rbr_rd = 0; id_rd = 0; msr_rd = 0; thr_wr = 0;
   endtask

   initial begin
      #(4 * 200000);
      miscompares++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      check("R1 reset", 8'h01);

      // Disabled line-status cause latches silently.
      int_en = 4'b0001;
      line_err = 4'b0010; tick();
      check("R8 masked", 8'h01);
      int_en = 4'b0101; #0.5;
      check("R8 unmask", 8'h06);
      rx_ready = 1; tick();
      check("R7 ls over rx", 8'h06);
      lsr_rd = 1; tick();
      check("R2 lsr clear", 8'h04);
      rbr_rd = 1; tick();
      check("R3 rbr clear", 8'h01);

      // Enable rise while holding register empty since reset.
      int_en = 4'b0111; tick();
      check("R10 enable arm", 8'h02);
      id_rd = 1; tick();
      check("R5 id read clears tx", 8'h01);
      thr_wr = 1; tick();
      thr_empty_evt = 1; tick();
      check("R4 tx set", 8'h02);
      thr_wr = 1; tick();
      check("R4 thr write clear", 8'h01);

      thr_empty_evt = 1; tick();
      line_err = 4'b1000; tick();
      check("R7 ls over tx", 8'h06);
      id_rd = 1; tick();
      lsr_rd = 1; tick();
      check("R5 tx kept", 8'h02);
      thr_wr = 1; tick();
      check("R4 clear", 8'h01);

      int_en = 4'b1111;
      for (int b = 0; b < 4; b++) begin
         modem_evt = 4'(1 << b); tick();
         check("R6 modem set", 8'h00);
         msr_rd = 1; tick();
         check("R6 msr clear", 8'h01);
      end
      for (int b = 0; b < 4; b++) begin
         line_err = 4'(1 << b); tick();
         check("R2 line set", 8'h06);
         lsr_rd = 1; tick();
         check("R2 lsr clear", 8'h01);
      end

      rx_ready = 1; rbr_rd = 1; tick();
      check("R11 set beats clear", 8'h04);
      rbr_rd = 1; tick();
      check("R3 clear", 8'h01);

      modem_evt = 4'b0100; #1;
      check("R12 no change before edge", 8'h01);
      tick();
      check("R12 after edge", 8'h00);
      int_en = 4'b0000; #0.5;
      check("R8 all masked", 8'h01);
      int_en = 4'b1111; #0.5;
      check("R8 re-enabled", 8'h00);
      msr_rd = 1; tick();
      check("R6 clear", 8'h01);

      tick();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule